// File: doc/BRIEF.md
# Multiport DRAM Cycle Mode Decoder

This block is the control front end of a dual-port video DRAM. It is written as synchronous logic that runs on a fast system clock. The active-low row and column strobes, the shared-function control pins and the nine multiplexed address pins all arrive asynchronously. Every one of them passes through the same two-stage synchronizer, so they stay aligned with one another. The block finds strobe edges by comparing each synchronized level with its value one clock earlier.

When the row strobe falls, the block captures the nine row bits. It also reads the levels of the transfer/output-enable pin, the write-mask/write-enable pin, the special-function pin and the serial-enable pin. From these levels it fixes the type of the cycle:
- a normal random access,
- a masked (write-per-bit) access,
- a block write,
- a read transfer (array to serial register),
- a write transfer (serial register to array).

After that point the pins fall back to their usual roles. When the column strobe falls, the block captures eight column bits and, in some cycles, refines the cycle type. The decode stays on the outputs until the row strobe rises again. Then a one-clock done pulse is issued and the block returns to standby.

Downstream array and serial-port logic use the latched addresses, the one-hot cycle type and the strobe pulses. They also use a gated output-enable that allows read data onto the pins only while the column strobe is low.

Top module: `vdram_cycle_decoder`

## Requirements
- R1: Out of reset, and at any time no cycle is active, `cycle_active` is 0, `cycle_kind` is all zero, and `mask_en`, `xfer_to_ram`, `col_strobe` and `data_oe` are 0.
- R2: A high-to-low change of `ras_n` latches all nine `addr` bits into `row_addr`, sets `cycle_active` and pulses `row_strobe` for one clock. These outputs change on the second rising edge after the first edge that samples `ras_n` low.
- R3: A high-to-low change of `cas_n` during an active cycle latches `addr[7:0]` into `col_addr` and pulses `col_strobe` for one clock, with the same latency as R2.
- R4: If `dtoe_n` is 0 at the row edge, the cycle is a transfer. `wbwe_n` at 1 gives `cycle_kind` bit 3 (read transfer) with `xfer_to_ram` 0. `wbwe_n` at 0 gives bit 4 (write transfer) with `xfer_to_ram` 1.
- R5: If `dtoe_n` is 1 at the row edge, the cycle is a RAM-port cycle. `wbwe_n` at 1 gives bit 0 (normal) with `mask_en` 0. `wbwe_n` at 0 gives bit 1 (masked write) with `mask_en` 1. At most one bit of `cycle_kind` is ever set.
- R6: In a RAM-port cycle with `dsf` 0 at the row edge, each column edge re-evaluates the type. `dsf` at 1 selects bit 2 (block write). `dsf` at 0 restores bit 0 or bit 1, as chosen by `mask_en`, which keeps its row-edge value.
- R7: In a RAM-port cycle with `dsf` 1 at the row edge, `dsf` at column edges has no effect on `cycle_kind`.
- R8: In a transfer cycle, column edges latch `col_addr` but leave `cycle_kind` and `xfer_to_ram` unchanged.
- R9: A column edge while no cycle is active leaves `col_addr` unchanged and gives no `col_strobe`. Instead it pulses `stray_cas` for one clock.
- R10: A low-to-high change of `ras_n` ends an active cycle. `cycle_done` pulses for one clock and `cycle_active`, `cycle_kind`, `mask_en` and `xfer_to_ram` clear. `row_addr`, `col_addr` and `se_held` keep their values.
- R11: While a cycle stays active, `row_addr`, `se_held` and `xfer_to_ram` do not change.
- R12: `data_oe` is 1 only in an active RAM-port cycle whose column has been latched, while both synchronized `cas_n` and synchronized `dtoe_n` are 0. It is always 0 in transfer cycles.
- R13: `se_held` takes the level of `se_n` at the row edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| dtoe_n | input | 1 | Transfer select at row edge, later output enable |
| wbwe_n | input | 1 | Mask/direction select at row edge, later write enable |
| dsf | input | 1 | Special-function select |
| se_n | input | 1 | Serial enable, captured only |
| addr | input | 9 | Multiplexed row/column address |
| row_addr | output | 9 | Latched row address |
| col_addr | output | 8 | Latched column address |
| cycle_active | output | 1 | A cycle is in progress |
| cycle_kind | output | 5 | One-hot cycle type (bit0 normal, 1 masked, 2 block, 3 read xfer, 4 write xfer) |
| xfer_to_ram | output | 1 | Write transfer direction flag |
| mask_en | output | 1 | Write-per-bit masking enabled |
| se_held | output | 1 | `se_n` level at the row edge |
| row_strobe | output | 1 | One-clock pulse on row capture |
| col_strobe | output | 1 | One-clock pulse on column capture |
| cycle_done | output | 1 | One-clock pulse when a cycle ends |
| stray_cas | output | 1 | One-clock pulse for a column edge in standby |
| data_oe | output | 1 | Read data may be driven |

## Verification
The bench starts cycles with each combination of transfer-select and mask-select levels. This shows that the row-edge decode picks among four distinct types and sets the direction flag only for write transfers. Column edges with the special-function pin high and then low, in masked, unmasked and special-at-row cycles, separate the block-write upgrade from the cases where that pin must be ignored. Column edges in standby and in transfer cycles show that column latching and type refinement are limited to the proper cycles. Row addresses with only the top bit set, all ones, and mixed patterns confirm that all nine bits are taken at the row edge and only eight at the column edge.

// File: rtl/vdram_dec_pkg.sv
package vdram_dec_pkg;

  localparam int KIND_W    = 5;
  localparam int KB_NORMAL = 0;
  localparam int KB_MASKED = 1;
  localparam int KB_BLOCK  = 2;
  localparam int KB_RDX    = 3;
  localparam int KB_WRX    = 4;

  function automatic logic [KIND_W-1:0] kind_bit(input int idx);
    logic [KIND_W-1:0] v;
    v      = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // type fixed by pin levels at the row edge
  function automatic logic [KIND_W-1:0] kind_at_row(input logic oe_n, input logic we_n);
    if (!oe_n) return we_n ? kind_bit(KB_RDX) : kind_bit(KB_WRX);
    return we_n ? kind_bit(KB_NORMAL) : kind_bit(KB_MASKED);
  endfunction

  // refinement at a column edge
  function automatic logic [KIND_W-1:0] kind_at_col(input logic [KIND_W-1:0] cur,
                                                    input logic masked,
                                                    input logic dsf_row,
                                                    input logic dsf_col);
    if (cur[KB_RDX] || cur[KB_WRX] || dsf_row) return cur;
    if (dsf_col) return kind_bit(KB_BLOCK);
    return masked ? kind_bit(KB_MASKED) : kind_bit(KB_NORMAL);
  endfunction

endpackage

// File: rtl/vdram_pin_sync.sv
module vdram_pin_sync #(
  parameter int             W       = 15,
  parameter int             DEPTH   = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int NST = (DEPTH < 1) ? 1 : DEPTH;

  logic [W-1:0] stg [NST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < NST; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[NST-1];

endmodule

// File: rtl/vdram_edge_det.sv
module vdram_edge_det #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fell,
  output logic [W-1:0] rose
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fell[i] =  prev_q[i] & ~lvl[i];
    assign rose[i] = ~prev_q[i] &  lvl[i];
  end

endmodule

// File: rtl/vdram_mode_decode.sv
module vdram_mode_decode
  import vdram_dec_pkg::*;
(
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [KIND_W-1:0] cur_kind,
  input  logic              masked,
  input  logic              dsf_row,
  input  logic              dsf_col,
  output logic [KIND_W-1:0] row_kind,
  output logic              row_xfer,
  output logic              row_to_ram,
  output logic              row_mask,
  output logic [KIND_W-1:0] col_kind
);

  always_comb begin
    row_kind   = kind_at_row(oe_n, we_n);
    row_xfer   = ~oe_n;
    row_to_ram = ~oe_n & ~we_n;
    row_mask   =  oe_n & ~we_n;
    col_kind   = kind_at_col(cur_kind, masked, dsf_row, dsf_col);
  end

  // R5
  always_comb begin
    kind_row_onehot_chk: assert ($onehot(row_kind));
  end

endmodule

// File: rtl/vdram_cycle_decoder.sv
module vdram_cycle_decoder
  import vdram_dec_pkg::*;
#(
  parameter int ROW_W      = 9,
  parameter int COL_W      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              dtoe_n,
  input  logic              wbwe_n,
  input  logic              dsf,
  input  logic              se_n,
  input  logic [ROW_W-1:0]  addr,
  output logic [ROW_W-1:0]  row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic              cycle_active,
  output logic [KIND_W-1:0] cycle_kind,
  output logic              xfer_to_ram,
  output logic              mask_en,
  output logic              se_held,
  output logic              row_strobe,
  output logic              col_strobe,
  output logic              cycle_done,
  output logic              stray_cas,
  output logic              data_oe
);

  localparam int PIN_W = ROW_W + 6;
  localparam int P_RAS = ROW_W;
  localparam int P_CAS = ROW_W + 1;
  localparam int P_OE  = ROW_W + 2;
  localparam int P_WE  = ROW_W + 3;
  localparam int P_DSF = ROW_W + 4;
  localparam int P_SE  = ROW_W + 5;

  logic [PIN_W-1:0] pin_raw, pin_s;

  assign pin_raw = {se_n, dsf, wbwe_n, dtoe_n, cas_n, ras_n, addr};

  vdram_pin_sync #(.W(PIN_W), .DEPTH(SYNC_DEPTH), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );

  logic ras_fall_w, ras_rise_w, cas_fall_w, cas_rose_unused;

  vdram_edge_det #(.W(1), .RST_VAL(1'b1)) u_ras_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pin_s[P_RAS]), .fell(ras_fall_w), .rose(ras_rise_w)
  );

  vdram_edge_det #(.W(1), .RST_VAL(1'b1)) u_cas_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pin_s[P_CAS]), .fell(cas_fall_w), .rose(cas_rose_unused)
  );

  // state
  logic              act_q, xfer_q, dir_q, mask_q, dsfr_q, se_q, cseen_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [KIND_W-1:0] kind_q;
  logic              rstb_q, cstb_q, done_q, stray_q;

  // decode
  logic [KIND_W-1:0] row_kind_w, col_kind_w;
  logic              row_xfer_w, row_dir_w, row_mask_w;

  vdram_mode_decode u_dec (
    .oe_n(pin_s[P_OE]), .we_n(pin_s[P_WE]),
    .cur_kind(kind_q), .masked(mask_q), .dsf_row(dsfr_q), .dsf_col(pin_s[P_DSF]),
    .row_kind(row_kind_w), .row_xfer(row_xfer_w), .row_to_ram(row_dir_w),
    .row_mask(row_mask_w), .col_kind(col_kind_w)
  );

  // named events
  logic end_w, col_take_w, stray_w;
  assign end_w      = ras_rise_w & act_q;
  assign col_take_w = cas_fall_w & act_q & ~ras_rise_w;
  assign stray_w    = cas_fall_w & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; xfer_q <= 1'b0; dir_q <= 1'b0; mask_q <= 1'b0;
      dsfr_q <= 1'b0; se_q <= 1'b1; cseen_q <= 1'b0;
      row_q <= '0; col_q <= '0; kind_q <= '0;
      rstb_q <= 1'b0; cstb_q <= 1'b0; done_q <= 1'b0; stray_q <= 1'b0;
    end else begin
      rstb_q  <= 1'b0;
      cstb_q  <= 1'b0;
      done_q  <= 1'b0;
      stray_q <= stray_w;
      if (ras_fall_w) begin
        act_q   <= 1'b1;
        row_q   <= pin_s[ROW_W-1:0];
        kind_q  <= row_kind_w;
        xfer_q  <= row_xfer_w;
        dir_q   <= row_dir_w;
        mask_q  <= row_mask_w;
        dsfr_q  <= pin_s[P_DSF];
        se_q    <= pin_s[P_SE];
        cseen_q <= 1'b0;
        rstb_q  <= 1'b1;
      end else if (end_w) begin
        act_q   <= 1'b0;
        kind_q  <= '0;
        xfer_q  <= 1'b0;
        dir_q   <= 1'b0;
        mask_q  <= 1'b0;
        cseen_q <= 1'b0;
        done_q  <= 1'b1;
      end else if (col_take_w) begin
        col_q   <= pin_s[COL_W-1:0];
        kind_q  <= col_kind_w;
        cseen_q <= 1'b1;
        cstb_q  <= 1'b1;
      end
    end
  end

  assign row_addr     = row_q;
  assign col_addr     = col_q;
  assign cycle_active = act_q;
  assign cycle_kind   = kind_q;
  assign xfer_to_ram  = dir_q;
  assign mask_en      = mask_q;
  assign se_held      = se_q;
  assign row_strobe   = rstb_q;
  assign col_strobe   = cstb_q;
  assign cycle_done   = done_q;
  assign stray_cas    = stray_q;
  assign data_oe      = act_q & ~xfer_q & cseen_q & ~pin_s[P_CAS] & ~pin_s[P_OE];

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_active |-> (cycle_kind == '0 && !data_oe && !col_strobe && !mask_en && !xfer_to_ram));

  // R5
  kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cycle_kind));

  // R4
  dir_write_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_to_ram |-> cycle_kind[KB_WRX]);

  // R11
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_active && $past(cycle_active)) |-> ($stable(row_addr) && $stable(se_held) && $stable(xfer_to_ram)));

  // R10
  done_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> (!cycle_active && $past(cycle_active)));

  // R9
  stray_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stray_cas |-> (!$past(cycle_active) && !col_strobe));

  // R3
  col_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_strobe |-> (cycle_active && $past(cycle_active)));

  // R12
  oe_ramport_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (cycle_kind[KB_NORMAL] || cycle_kind[KB_MASKED] || cycle_kind[KB_BLOCK]));

endmodule

// File: tb/vdram_cycle_decoder_test.sv
module vdram_cycle_decoder_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, dtoe_n = 1'b1, wbwe_n = 1'b1, dsf = 1'b0, se_n = 1'b1;
  logic [8:0] addr = '0;
  logic [8:0] row_addr;
  logic [7:0] col_addr;
  logic       cycle_active, xfer_to_ram, mask_en, se_held;
  logic [4:0] cycle_kind;
  logic       row_strobe, col_strobe, cycle_done, stray_cas, data_oe;

  vdram_cycle_decoder uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .dtoe_n(dtoe_n),
    .wbwe_n(wbwe_n), .dsf(dsf), .se_n(se_n), .addr(addr),
    .row_addr(row_addr), .col_addr(col_addr), .cycle_active(cycle_active),
    .cycle_kind(cycle_kind), .xfer_to_ram(xfer_to_ram), .mask_en(mask_en),
    .se_held(se_held), .row_strobe(row_strobe), .col_strobe(col_strobe),
    .cycle_done(cycle_done), .stray_cas(stray_cas), .data_oe(data_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: pin history, newest first
  typedef struct packed {
    logic se, dsf, we, oe, cas, ras;
    logic [8:0] a;
  } pins_t;

  pins_t hq[$];
  int    m_kind;          // -1 = none, else one-hot bit index
  bit    m_act, m_xfer, m_dir, m_mask, m_dsfr, m_se, m_cseen;
  bit    m_rstb, m_cstb, m_done, m_stray, m_oe;
  int    m_row, m_col;

  function automatic pins_t idle_pins();
    pins_t p;
    p = '1;
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hq = {};
      for (int i = 0; i < 4; i++) hq.push_back(idle_pins());
      m_kind = -1; m_act = 0; m_xfer = 0; m_dir = 0; m_mask = 0; m_dsfr = 0;
      m_se = 1; m_cseen = 0; m_rstb = 0; m_cstb = 0; m_done = 0; m_stray = 0;
      m_oe = 0; m_row = 0; m_col = 0;
    end else begin
      pins_t cur, old, dly;
      bit was_act;
      hq.push_front({se_n, dsf, wbwe_n, dtoe_n, cas_n, ras_n, addr});
      void'(hq.pop_back());
      cur = hq[2];
      old = hq[3];
      dly = hq[1];
      was_act = m_act;
      m_rstb = 0; m_cstb = 0; m_done = 0;
      m_stray = (old.cas && !cur.cas && !was_act);
      if (old.ras && !cur.ras) begin
        m_act = 1; m_row = cur.a; m_se = cur.se; m_dsfr = cur.dsf; m_cseen = 0; m_rstb = 1;
        m_xfer = !cur.oe;
        m_dir  = !cur.oe && !cur.we;
        m_mask = cur.oe && !cur.we;
        if (!cur.oe) m_kind = cur.we ? 3 : 4;
        else         m_kind = cur.we ? 0 : 1;
      end else if (!old.ras && cur.ras && was_act) begin
        m_act = 0; m_kind = -1; m_xfer = 0; m_dir = 0; m_mask = 0; m_cseen = 0; m_done = 1;
      end else if (old.cas && !cur.cas && was_act) begin
        m_col = cur.a % 256; m_cseen = 1; m_cstb = 1;
        if (!m_xfer && !m_dsfr) m_kind = cur.dsf ? 2 : (m_mask ? 1 : 0);
      end
      m_oe = m_act && !m_xfer && m_cseen && !dly.cas && !dly.oe;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R1",  "cycle_active", cycle_active, m_act);
      chk("R2",  "row_addr",     row_addr,     m_row);
      chk("R2",  "row_strobe",   row_strobe,   m_rstb);
      chk("R3",  "col_addr",     col_addr,     m_col);
      chk("R3",  "col_strobe",   col_strobe,   m_cstb);
      chk("R5",  "cycle_kind",   cycle_kind,   (m_kind < 0) ? 0 : (1 << m_kind));
      chk("R4",  "xfer_to_ram",  xfer_to_ram,  m_dir);
      chk("R5",  "mask_en",      mask_en,      m_mask);
      chk("R13", "se_held",      se_held,      m_se);
      chk("R10", "cycle_done",   cycle_done,   m_done);
      chk("R9",  "stray_cas",    stray_cas,    m_stray);
      chk("R12", "data_oe",      data_oe,      m_oe);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic row_open(input logic [8:0] row, input logic oe_n, input logic we_n,
                          input logic f, input logic s, input logic [4:0] exp_kind);
    addr = row; dtoe_n = oe_n; wbwe_n = we_n; dsf = f; se_n = s;
    wait_n(2);
    ras_n = 1'b0;
    wait_n(4);
    chk("R2",  "row latch", row_addr, row);
    chk("R2",  "active",    cycle_active, 1);
    chk("R4",  "row kind",  cycle_kind, exp_kind);
    chk("R13", "se capture", se_held, s);
    dtoe_n = 1'b1; wbwe_n = 1'b1;
    wait_n(2);
  endtask

  task automatic col_pulse(input logic [8:0] col, input logic f, input logic oe_n,
                           input logic [4:0] exp_kind, input logic exp_oe);
    addr = col; dsf = f; dtoe_n = oe_n;
    wait_n(2);
    cas_n = 1'b0;
    wait_n(4);
    chk("R3",  "col latch", col_addr, col[7:0]);
    chk("R6",  "col kind",  cycle_kind, exp_kind);
    chk("R12", "data_oe in col", data_oe, exp_oe);
    cas_n = 1'b1; dtoe_n = 1'b1;
    wait_n(3);
  endtask

  task automatic row_close();
    ras_n = 1'b1;
    wait_n(5);
    chk("R10", "kind cleared", cycle_kind, 0);
    chk("R10", "inactive", cycle_active, 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    wait_n(2);
    // R1 reset state
    chk("R1", "reset active", cycle_active, 0);
    chk("R1", "reset kind",   cycle_kind, 0);
    chk("R1", "reset oe",     data_oe, 0);

    // R5 normal access, top row bit only
    row_open(9'h100, 1'b1, 1'b1, 1'b0, 1'b1, 5'b00001);
    col_pulse(9'h13C, 1'b0, 1'b0, 5'b00001, 1'b1);
    chk("R5", "normal no mask", mask_en, 0);
    row_close();
    chk("R10", "row kept", row_addr, 9'h100);
    chk("R10", "col kept", col_addr, 8'h3C);

    // R5 R6 masked, then block write, then back
    row_open(9'h1FF, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00010);
    chk("R5", "mask on", mask_en, 1);
    col_pulse(9'h0A5, 1'b1, 1'b1, 5'b00100, 1'b0);
    chk("R6", "mask kept in block", mask_en, 1);
    col_pulse(9'h05A, 1'b0, 1'b0, 5'b00010, 1'b1);
    row_close();
    chk("R13", "se held after end", se_held, 0);

    // R6 unmasked block write
    row_open(9'h0C3, 1'b1, 1'b1, 1'b0, 1'b1, 5'b00001);
    col_pulse(9'h0FF, 1'b1, 1'b0, 5'b00100, 1'b1);
    row_close();

    // R7 special function at row: column dsf ignored
    row_open(9'h033, 1'b1, 1'b1, 1'b1, 1'b1, 5'b00001);
    col_pulse(9'h011, 1'b1, 1'b1, 5'b00001, 1'b0);
    row_close();

    // R4 R8 read transfer, column dsf and oe ignored
    row_open(9'h155, 1'b0, 1'b1, 1'b0, 1'b1, 5'b01000);
    chk("R4", "read dir", xfer_to_ram, 0);
    col_pulse(9'h1AA, 1'b1, 1'b0, 5'b01000, 1'b0);
    chk("R8", "xfer col latched", col_addr, 8'hAA);
    row_close();

    // R4 write transfer
    row_open(9'h0AA, 1'b0, 1'b0, 1'b0, 1'b0, 5'b10000);
    chk("R4", "write dir", xfer_to_ram, 1);
    col_pulse(9'h077, 1'b0, 1'b1, 5'b10000, 1'b0);
    row_close();
    chk("R10", "dir cleared", xfer_to_ram, 0);

    // R9 stray column edge in standby
    addr = 9'h0EE;
    wait_n(2);
    cas_n = 1'b0;
    wait_n(4);
    chk("R9", "stray col unchanged", col_addr, 8'h77);
    chk("R9", "stray no strobe", col_strobe, 0);
    cas_n = 1'b1;
    wait_n(6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule